// File: doc/BRIEF.md
# Serial Video NRZI Decoder and Self-Synchronizing Descrambler

This block sits on the receive side of a serial digital video link and works at the serial bit rate. The nominal rate is 270 Mb/s, which is ten times the 27 MHz word rate. It takes one sliced line bit per accepted beat and undoes the two coding layers of the link, in a fixed order. The first stage removes the polarity-free NRZI line code, which uses the polynomial x+1: each decoded bit is the XOR of the current raw bit and the previous raw bit. The second stage descrambles the decoded stream with the self-synchronizing inverse of the x^9+x^4+1 scrambler. The result is the original NRZ bit stream, one bit per accepted beat.

A mode pin sends raw bits straight to the output for streams that carry no such coding. Bits move through valid/ready streams. An input beat is taken only when `s_ready` is high, and `s_ready` is high whenever the output holding register is empty or is being drained in the same cycle. While the output is offered and not taken, its bit and flag stay unchanged and no new input is accepted. A flag that travels with each output bit marks where the descrambler history starts to hold real line data.

Top module: `sdi_nrzi_descrambler`

## Requirements
- R1: In decode mode, the NRZI stage produces d[n] = raw[n] XOR raw[n-1] over accepted beats. After reset the previous raw bit is taken as 0.
- R2: In decode mode, each output bit is d[n] XOR d[n-4] XOR d[n-9]. Here d[n-k] is the decoded bit from k accepted beats earlier.
- R3: Reset clears all history to 0. From reset, the raw decode-mode beats 1,1,0,0,0 produce the outputs 1,0,1,0,1.
- R4: The output is polarity free. A stream made by scrambling and then NRZI-encoding a message, whether sent inverted or not, returns the exact message on every output beat whose settled flag is high.
- R5: When `bypass` is 1, the output bit equals the accepted raw bit. The NRZI and descrambler history still advance on that beat. So, from reset, a bypassed 1 followed by a decoded 1 produces a 0 for the decoded beat.
- R6: An accepted beat appears at the output on the next clock with `m_valid` high. When `m_ready` is 1 and nothing is accepted, `m_valid` falls on the next clock.
- R7: While `m_valid` is 1 and `m_ready` is 0, `s_ready` is 0, and `m_bit` and `m_settled` hold their values.
- R8: `m_settled` is 0 on the first 10 output beats after reset. It is 1 from the 11th output beat on, and it stays 1 until the next reset.
- R9: During reset and right after it, `m_valid` and `m_settled` are 0 and `s_ready` is 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass | input | 1 | 1: pass raw bits through; 0: decode and descramble |
| s_valid | input | 1 | Input bit offered |
| s_ready | output | 1 | Input bit can be taken this cycle |
| s_bit | input | 1 | Raw sliced line bit |
| m_valid | output | 1 | Output bit held |
| m_ready | input | 1 | Downstream takes the output bit |
| m_bit | output | 1 | Recovered bit |
| m_settled | output | 1 | History holds real line data; the bit is trustworthy |

## Verification
Every result, whether in decode mode, in bypass or for the settled flag, appears one clock after the edge that accepts its input beat. The bench drives inputs on the falling edge and reads outputs at the next falling edge, which is one register after acceptance. Stall checks read `s_ready` within the same cycle, since it is combinational. They then read the held output at the following falling edge, and read it again after release, one clock after the beat that was let in. The round-trip runs compare only on beats that carry the settled flag, because earlier beats still depend on history from before the stream began.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;
  // scrambler polynomial x^LEN + x^TAP + 1
  localparam int unsigned SCR_LEN = 9;
  localparam int unsigned SCR_TAP = 4;
  // beats needed before every tap holds line data: LEN decoded bits plus one raw bit
  localparam int unsigned WARMUP_BEATS = SCR_LEN + 1;

  typedef enum logic {MODE_DECODE = 1'b0, MODE_PASS = 1'b1} rx_mode_e;
endpackage

// File: rtl/sdi_nrzi_stage.sv
module sdi_nrzi_stage (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic raw,
  output logic dec
);
  logic prev_q;

  assign dec = raw ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst)      prev_q <= 1'b0;
    else if (adv) prev_q <= raw;
  end
endmodule

// File: rtl/sdi_descram_stage.sv
module sdi_descram_stage #(
  parameter int unsigned LEN = 9,
  parameter int unsigned TAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output logic dout
);
  // hist_q[k] holds the decoded bit from k+1 accepted beats ago
  logic [LEN-1:0] hist_q;
  logic [LEN-1:0] hist_d;

  generate
    if (LEN > 1) begin : g_shift
      assign hist_d = {hist_q[LEN-2:0], din};
    end else begin : g_single
      assign hist_d = din;
    end
  endgenerate

  assign dout = din ^ hist_q[TAP-1] ^ hist_q[LEN-1];

  always_ff @(posedge clk) begin
    if (rst)      hist_q <= '0;
    else if (adv) hist_q <= hist_d;
  end
endmodule

// File: rtl/sdi_warmup_ctr.sv
module sdi_warmup_ctr #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic full
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign full = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (adv && !full) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdi_nrzi_descrambler.sv
module sdi_nrzi_descrambler
  import sdi_rx_pkg::*;
#(
  parameter int unsigned LEN = SCR_LEN,
  parameter int unsigned TAP = SCR_TAP
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_bit,
  output logic m_valid,
  input  logic m_ready,
  output logic m_bit,
  output logic m_settled
);
  localparam int unsigned FILL = LEN + 1;

  logic     accept;
  logic     dec_bit;
  logic     desc_bit;
  logic     hist_full;
  rx_mode_e mode;

  assign mode    = rx_mode_e'(bypass);
  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  sdi_nrzi_stage u_nrzi (
    .clk (clk),
    .rst (rst),
    .adv (accept),
    .raw (s_bit),
    .dec (dec_bit)
  );

  sdi_descram_stage #(.LEN(LEN), .TAP(TAP)) u_desc (
    .clk  (clk),
    .rst  (rst),
    .adv  (accept),
    .din  (dec_bit),
    .dout (desc_bit)
  );

  sdi_warmup_ctr #(.LIMIT(FILL)) u_warm (
    .clk  (clk),
    .rst  (rst),
    .adv  (accept),
    .full (hist_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid   <= 1'b0;
      m_bit     <= 1'b0;
      m_settled <= 1'b0;
    end else if (accept) begin
      m_valid   <= 1'b1;
      m_bit     <= (mode == MODE_PASS) ? s_bit : desc_bit;
      m_settled <= hist_full;
    end else if (m_ready) begin
      m_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/sdi_nrzi_descrambler_chk.sv
module sdi_nrzi_descrambler_chk (
  input logic clk,
  input logic rst,
  input logic bypass,
  input logic s_valid,
  input logic s_ready,
  input logic s_bit,
  input logic m_valid,
  input logic m_ready,
  input logic m_bit,
  input logic m_settled
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_bit) && $stable(m_settled)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  // R6
  accept_out_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> m_valid);

  // R5
  pass_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && bypass) |=> (m_bit == $past(s_bit)));

  // R8
  settled_keep_chk: assert property (@(posedge clk) disable iff (rst)
    m_settled |=> m_settled);

  // R8
  settled_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_settled |-> m_valid || $past(m_settled));
endmodule

bind sdi_nrzi_descrambler sdi_nrzi_descrambler_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bypass    (bypass),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_bit     (s_bit),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_bit     (m_bit),
  .m_settled (m_settled)
);

// File: tb/tb_sdi_nrzi_descrambler.sv
module tb_sdi_nrzi_descrambler;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bypass = 1'b0;
  logic s_valid = 1'b0;
  logic s_bit = 1'b0;
  logic m_ready = 1'b1;
  logic s_ready, m_valid, m_bit, m_settled;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdi_nrzi_descrambler dut (
    .clk(clk), .rst(rst), .bypass(bypass),
    .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit), .m_settled(m_settled)
  );

  // {bypass, raw bit, expected output}; runs straight from reset
  localparam logic [2:0] VEC [9] = '{
    3'b0_1_1, 3'b0_1_0, 3'b0_0_1, 3'b0_0_0, 3'b0_0_1,
    3'b1_1_1, 3'b1_0_0, 3'b1_0_0, 3'b1_1_1
  };

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_valid = 1'b0; m_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // offer one beat at a falling edge, return at the next falling edge
  task automatic step(input logic b, input logic byp);
    s_valid = 1'b1; s_bit = b; bypass = byp;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic round_trip(input logic inv, input int nbits);
    logic [8:0] sc = '0;
    logic tprev = 1'b0;
    int miss = 0;
    int seen = 0;
    do_reset();
    for (int i = 0; i < nbits; i++) begin
      logic x, s, t;
      x = 1'($urandom_range(0, 1));
      s = x ^ sc[3] ^ sc[8];
      sc = {sc[7:0], s};
      t = s ^ tprev;
      tprev = t;
      step(t ^ inv, 1'b0);
      if (m_settled) begin
        seen++;
        if (m_bit !== x) miss++;
      end
    end
    chk(miss == 0 && seen == nbits - 10, 1'b1, inv ? "R4 inverted" : "R4 upright");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    @(negedge clk);
    chk(m_valid, 1'b0, "R9 m_valid");
    chk(m_settled, 1'b0, "R9 m_settled");
    chk(s_ready, 1'b1, "R9 s_ready");
    do_reset();
    chk(m_valid, 1'b0, "R9 m_valid after release");

    // R1 R2 R3 R5: vector table from reset
    foreach (VEC[i]) begin
      step(VEC[i][1], VEC[i][2]);
      chk(m_bit, VEC[i][0], VEC[i][2] ? "R5 pass vector" : "R3 decode vector");
    end

    // R6 latency and drain
    do_reset();
    step(1'b1, 1'b1);
    chk(m_valid, 1'b1, "R6 valid after accept");
    @(negedge clk);
    chk(m_valid, 1'b0, "R6 drained");

    // R5 history advances in bypass
    do_reset();
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    chk(m_bit, 1'b0, "R5 history advanced");

    // R7 back-pressure
    do_reset();
    m_ready = 1'b0;
    step(1'b1, 1'b1);
    s_valid = 1'b1; s_bit = 1'b0;
    #1;
    chk(s_ready, 1'b0, "R7 s_ready low");
    @(negedge clk);
    chk(m_bit, 1'b1, "R7 bit held");
    chk(m_valid, 1'b1, "R7 valid held");
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk(m_bit, 1'b0, "R7 beat taken after release");

    // R8 settled flag
    do_reset();
    for (int i = 0; i < 10; i++) begin
      step(1'($urandom_range(0, 1)), 1'b0);
      chk(m_settled, 1'b0, "R8 warming");
    end
    step(1'b0, 1'b0);
    chk(m_settled, 1'b1, "R8 settled at 11th");
    @(negedge clk);
    step(1'b1, 1'b1);
    chk(m_settled, 1'b1, "R8 stays settled");

    // R4 R1 R2 round trips
    round_trip(1'b0, 300);
    round_trip(1'b1, 300);
    round_trip(1'b1, 150);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule